// File: doc/BRIEF.md
# AXI Read Burst Responder

This block sits on the slave side of an AXI read address and read data channel pair. It takes one read request at a time and answers it with a single uninterrupted burst of read data beats. The data comes from a small byte-addressed ROM inside the block. The ROM's contents are computed from each byte's address.

The lane placement is not the usual one. The first beat of a burst is aligned to the start address: the bytes from the start address onward occupy the lanes selected by the low address bits, and the lanes below them are zero. Every later beat is packed from byte lane zero and carries the next consecutive word of memory. Transfer size is always the full bus width. ARLEN gives the number of beats minus one. The block marks the final beat, returns the request's ID, always answers OKAY, and holds each beat steady under backpressure. While a burst is running, the block does not accept a new request.

Top module: `axrd_responder`

## Requirements
- R1: When reset is released, ar_ready is 1 and r_valid is 0.
- R2: ar_ready is high exactly when no burst is in progress. A request is taken only in a cycle where ar_valid and ar_ready are both high, so at most one request is outstanding.
- R3: A request taken with ar_len = n is answered with exactly n+1 beats. r_valid rises in the cycle after the request is taken and stays high until the last beat is accepted.
- R4: The first beat uses off = ar_addr[1:0] and base = ar_addr with its two low bits cleared. For each lane j with j >= off, byte lane j (bits 8j+7..8j) carries mem[base+j]. Lanes j < off are 0.
- R5: Beat k (k >= 1) carries mem[base+4k+j] on byte lane j for every lane j = 0..3, so the data is packed from the least significant lane.
- R6: The memory byte at address a is (29*a + 17) mod 256. Addresses are 8 bits wide and wrap modulo 256.
- R7: r_last is 1 on the final beat of a burst and 0 on every other beat.
- R8: While r_valid is 1 and r_ready is 0, r_valid, r_data, r_last and r_id keep their values into the next cycle.
- R9: r_id equals the ar_id of the request being answered for every beat of the burst, and r_resp is 2'b00 (OKAY).
- R10: Bursts never interleave. In the cycle after the last beat is accepted, r_valid is 0, and the next burst begins only after a new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Block can take a read request |
| ar_addr | input | 8 | Start byte address |
| ar_id | input | 4 | Request ID |
| ar_len | input | 8 | Beats in the burst minus one |
| r_valid | output | 1 | Read data beat valid |
| r_ready | input | 1 | Master accepts the beat |
| r_data | output | 32 | Read data beat |
| r_id | output | 4 | ID of the request being answered |
| r_resp | output | 2 | Response code, always OKAY |
| r_last | output | 1 | Final beat of the burst |

## Verification
The hardest case to reach is a burst stalled on its final beat by r_ready while the next request is already waiting on ar_valid. In that case r_last and the data must hold, ar_ready must stay low, and the waiting request may be taken only after the final handshake. The stimulus gets there by presenting the next request zero to two cycles after the previous one is taken, and by applying random r_ready stalls at rates of up to 75 percent. Lengths up to sixteen beats and start addresses near 0xFF cover every first-beat offset and the address wrap.

// File: rtl/axrd_pkg.sv
package axrd_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axrd_beat_ctrl.sv
module axrd_beat_ctrl
    import axrd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 4,
    parameter int LEN_W  = 8,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid_i,
    input  logic [ADDR_W-1:0] ar_addr_i,
    input  logic [ID_W-1:0]   ar_id_i,
    input  logic [LEN_W-1:0]  ar_len_i,
    input  logic              r_ready_i,
    output logic              ar_ready_o,
    output logic              r_valid_o,
    output logic              r_last_o,
    output logic [ID_W-1:0]   r_id_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] nxt_widx_o,
    output logic              nxt_first_o,
    output logic [$clog2(NBYTES)-1:0] nxt_off_o
);

    localparam int OFF_W = $clog2(NBYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NBYTES);

    typedef struct packed {
        phase_e            phase;
        logic [LEN_W-1:0]  remain;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] widx;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  take_req;
    logic  beat_done;
    logic [ADDR_W-1:0] aligned;

    always_comb begin
        s_d         = s_q;
        take_req    = ar_valid_i && (s_q.phase == PH_IDLE);
        beat_done   = r_ready_i && (s_q.phase == PH_SEND);
        aligned     = {ar_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        load_o      = 1'b0;
        nxt_widx_o  = s_q.widx + STEP;
        nxt_first_o = 1'b0;
        nxt_off_o   = '0;

        if (take_req) begin
            s_d.phase   = PH_SEND;
            s_d.remain  = ar_len_i;
            s_d.id      = ar_id_i;
            s_d.widx    = aligned;
            load_o      = 1'b1;
            nxt_widx_o  = aligned;
            nxt_first_o = 1'b1;
            nxt_off_o   = ar_addr_i[OFF_W-1:0];
        end else if (beat_done) begin
            if (s_q.remain == '0) begin
                s_d.phase = PH_IDLE;
            end else begin
                s_d.remain = s_q.remain - 1'b1;
                s_d.widx   = s_q.widx + STEP;
                load_o     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, remain: '0, id: '0, widx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ar_ready_o = (s_q.phase == PH_IDLE);
    assign r_valid_o  = (s_q.phase == PH_SEND);
    assign r_last_o   = (s_q.phase == PH_SEND) && (s_q.remain == '0);
    assign r_id_o     = s_q.id;

endmodule

// File: rtl/axrd_byte_rom.sv
module axrd_byte_rom #(
    parameter int ADDR_W  = 8,
    parameter int NBYTES  = 4,
    parameter int PAT_MUL = 29,
    parameter int PAT_ADD = 17
) (
    input  logic [ADDR_W-1:0]   widx_i,
    output logic [8*NBYTES-1:0] word_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam int VAL = (i * PAT_MUL + PAT_ADD) % 256;
        assign rom[i] = 8'(VAL);
    end

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        localparam logic [ADDR_W-1:0] LJ = ADDR_W'(j);
        logic [ADDR_W-1:0] idx;
        assign idx = widx_i + LJ;
        assign word_o[8*j +: 8] = rom[idx];
    end

endmodule

// File: rtl/axrd_lane_place.sv
module axrd_lane_place #(
    parameter int NBYTES = 4
) (
    input  logic [8*NBYTES-1:0]       word_i,
    input  logic                      first_i,
    input  logic [$clog2(NBYTES)-1:0] off_i,
    output logic [8*NBYTES-1:0]       data_o
);

    localparam int OFF_W = $clog2(NBYTES);

    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        localparam logic [OFF_W-1:0] LJ = OFF_W'(j);
        assign data_o[8*j +: 8] = (first_i && (LJ < off_i)) ? 8'h00 : word_i[8*j +: 8];
    end

endmodule

// File: rtl/axrd_responder.sv
module axrd_responder
    import axrd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = 4,
    parameter int LEN_W   = 8,
    parameter int PAT_MUL = 29,
    parameter int PAT_ADD = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [LEN_W-1:0]  ar_len,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [ID_W-1:0]   r_id,
    output logic [1:0]        r_resp,
    output logic              r_last
);

    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } out_t;

    out_t out_d, out_q;

    logic              load;
    logic [ADDR_W-1:0] nxt_widx;
    logic              nxt_first;
    logic [OFF_W-1:0]  nxt_off;
    logic [DATA_W-1:0] rom_word;
    logic [DATA_W-1:0] placed;

    axrd_beat_ctrl #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .LEN_W  (LEN_W),
        .NBYTES (NBYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ar_valid_i  (ar_valid),
        .ar_addr_i   (ar_addr),
        .ar_id_i     (ar_id),
        .ar_len_i    (ar_len),
        .r_ready_i   (r_ready),
        .ar_ready_o  (ar_ready),
        .r_valid_o   (r_valid),
        .r_last_o    (r_last),
        .r_id_o      (r_id),
        .load_o      (load),
        .nxt_widx_o  (nxt_widx),
        .nxt_first_o (nxt_first),
        .nxt_off_o   (nxt_off)
    );

    axrd_byte_rom #(
        .ADDR_W  (ADDR_W),
        .NBYTES  (NBYTES),
        .PAT_MUL (PAT_MUL),
        .PAT_ADD (PAT_ADD)
    ) u_rom (
        .widx_i (nxt_widx),
        .word_o (rom_word)
    );

    axrd_lane_place #(
        .NBYTES (NBYTES)
    ) u_place (
        .word_i  (rom_word),
        .first_i (nxt_first),
        .off_i   (nxt_off),
        .data_o  (placed)
    );

    always_comb begin
        out_d = out_q;
        if (load) begin
            out_d.rdata = placed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign r_data = out_q.rdata;
    assign r_resp = RESP_OKAY;

endmodule

// File: rtl/axrd_responder_chk.sv
module axrd_responder_chk #(
    parameter int DATA_W = 32,
    parameter int ID_W   = 4,
    parameter int LEN_W  = 8,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [OFF_W-1:0]  ar_off,
    input logic [LEN_W-1:0]  ar_len,
    input logic              r_valid,
    input logic              r_ready,
    input logic [DATA_W-1:0] r_data,
    input logic [ID_W-1:0]   r_id,
    input logic              r_last
);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            beats_q <= '0;
        end else if (ar_valid && ar_ready) begin
            len_q   <= ar_len;
            beats_q <= '0;
        end else if (r_valid && r_ready) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    // R3: a taken request yields a beat on the next cycle
    p_start_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> r_valid);

    // R3: the last flag appears after exactly ar_len accepted beats
    p_beat_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_last) |-> (beats_q == len_q));

    // R2: a burst that has not finished keeps the request channel closed
    p_one_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !(r_ready && r_last)) |=> (r_valid && !ar_ready));

    // R8: a stalled beat is held
    p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ready) |=>
            (r_valid && $stable(r_data) && $stable(r_last) && $stable(r_id)));

    // R4: lane zero of an unaligned first beat is zero
    p_low_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready && (ar_off != '0)) |=> (r_data[7:0] == 8'h00));

    // R9: the ID does not change inside a burst
    p_id_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && !r_last) |=> $stable(r_id));

    // R10: a finished burst leaves a cycle without valid data
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && r_last) |=> !r_valid);

endmodule

bind axrd_responder axrd_responder_chk #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .LEN_W  (LEN_W),
    .OFF_W  ($clog2(DATA_W / 8))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_off   (ar_addr[$clog2(DATA_W / 8)-1:0]),
    .ar_len   (ar_len),
    .r_valid  (r_valid),
    .r_ready  (r_ready),
    .r_data   (r_data),
    .r_id     (r_id),
    .r_last   (r_last)
);

// File: tb/test_axrd_responder.sv
`timescale 1ns/1ps
module test_axrd_responder;

    localparam int LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ar_valid;
    logic        ar_ready;
    logic [7:0]  ar_addr;
    logic [3:0]  ar_id;
    logic [7:0]  ar_len;
    logic        r_valid;
    logic        r_ready;
    logic [31:0] r_data;
    logic [3:0]  r_id;
    logic [1:0]  r_resp;
    logic        r_last;

    always #4 clk = ~clk;

    axrd_responder i_axrd_responder (
        .clk      (clk),
        .rst_n    (rst_n),
        .ar_valid (ar_valid),
        .ar_ready (ar_ready),
        .ar_addr  (ar_addr),
        .ar_id    (ar_id),
        .ar_len   (ar_len),
        .r_valid  (r_valid),
        .r_ready  (r_ready),
        .r_data   (r_data),
        .r_id     (r_id),
        .r_resp   (r_resp),
        .r_last   (r_last)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_data [$];
    bit          exp_last [$];
    bit          exp_first[$];
    logic [3:0]  exp_id   [$];

    int rq_addr[$];
    int rq_len [$];
    int rq_id  [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R6: memory byte pattern
    function automatic logic [7:0] mem_byte(input int a);
        return 8'((((a % 256) * 29) + 17) % 256);
    endfunction

    task automatic expect_burst(input int a, input int len, input int id);
        int base = a & ~3;
        int off  = a & 3;
        for (int k = 0; k <= len; k++) begin
            logic [31:0] w = '0;
            for (int j = 0; j < 4; j++) begin
                logic [7:0] b = (k == 0 && j < off) ? 8'h00 : mem_byte(base + 4 * k + j);
                w[8*j +: 8] = b;
            end
            exp_data.push_back(w);
            exp_last.push_back(k == len);
            exp_first.push_back(k == 0);
            exp_id.push_back(4'(id));
        end
    endtask

    task automatic add_req(input int a, input int len, input int id);
        rq_addr.push_back(a);
        rq_len.push_back(len);
        rq_id.push_back(id);
    endtask

    initial begin
        int cyc = 0;
        int next_req = 0;
        int done = 0;
        int gap = 0;
        int stall_pct = 0;
        bit ar_taken = 0;
        bit prev_stall = 0;
        logic [31:0] prev_data = '0;
        bit prev_last = 0;
        logic [3:0] prev_id = '0;
        bit hs_ar, hs_r;

        rst_n = 1'b0; ar_valid = 1'b0; ar_addr = '0; ar_id = '0; ar_len = '0; r_ready = 1'b0;

        // directed corner cases: every first-beat offset, single beats, wrap, long bursts
        add_req(8'h00, 0, 1);
        add_req(8'h01, 3, 2);
        add_req(8'h02, 1, 3);
        add_req(8'h03, 0, 4);
        add_req(8'hFD, 4, 5);
        add_req(8'hF6, 15, 6);
        add_req(8'h40, 7, 7);
        add_req(8'hFF, 2, 8);
        for (int i = 0; i < 30; i++) begin
            add_req(int'($urandom_range(255)), int'($urandom_range(9)), int'($urandom_range(15)));
        end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ar_ready == 1'b1, "R1 ar_ready after reset", 32'(ar_ready), 32'd1);
        check(r_valid == 1'b0, "R1 r_valid after reset", 32'(r_valid), 32'd0);

        while (cyc < LIMIT && !(done == rq_addr.size() && exp_data.size() == 0)) begin
            @(negedge clk);
            cyc++;

            if (exp_data.size() == 0) begin
                check(r_valid == 1'b0, "R10 r_valid idle between bursts", 32'(r_valid), 32'd0);
                check(ar_ready == 1'b1, "R2 ar_ready while idle", 32'(ar_ready), 32'd1);
            end else begin
                check(r_valid == 1'b1, "R3 r_valid during burst", 32'(r_valid), 32'd1);
                check(ar_ready == 1'b0, "R2 ar_ready low during burst", 32'(ar_ready), 32'd0);
                if (exp_first[0])
                    check(r_data == exp_data[0], "R4,R6 first beat lanes", r_data, exp_data[0]);
                else
                    check(r_data == exp_data[0], "R5,R6 packed later beat", r_data, exp_data[0]);
                check(r_last == exp_last[0], "R7 r_last position", 32'(r_last), 32'(exp_last[0]));
                check(r_id == exp_id[0], "R9 r_id", 32'(r_id), 32'(exp_id[0]));
                check(r_resp == 2'b00, "R9 r_resp OKAY", 32'(r_resp), 32'd0);
            end
            if (prev_stall) begin
                check(r_valid == 1'b1, "R8 valid held", 32'(r_valid), 32'd1);
                check(r_data == prev_data, "R8 data held", r_data, prev_data);
                check(r_last == prev_last, "R8 last held", 32'(r_last), 32'(prev_last));
                check(r_id == prev_id, "R8 id held", 32'(r_id), 32'(prev_id));
            end

            if (ar_taken) begin
                ar_valid = 1'b0;
                ar_taken = 1'b0;
                gap = int'($urandom_range(2));
            end
            if (!ar_valid && next_req < rq_addr.size()) begin
                if (gap == 0) begin
                    ar_valid = 1'b1;
                    ar_addr  = 8'(rq_addr[next_req]);
                    ar_len   = 8'(rq_len[next_req]);
                    ar_id    = 4'(rq_id[next_req]);
                end else begin
                    gap--;
                end
            end
            stall_pct = (next_req < 4) ? 0 : (next_req < 14) ? 40 : 75;
            r_ready = (int'($urandom_range(99)) >= stall_pct);

            #1;
            hs_ar = ar_valid && ar_ready;
            hs_r  = r_valid && r_ready;
            prev_stall = r_valid && !r_ready;
            prev_data  = r_data;
            prev_last  = r_last;
            prev_id    = r_id;
            if (hs_r && exp_data.size() > 0) begin
                if (exp_last[0]) done++;
                void'(exp_data.pop_front());
                void'(exp_last.pop_front());
                void'(exp_first.pop_front());
                void'(exp_id.pop_front());
            end
            if (hs_ar) begin
                expect_burst(rq_addr[next_req], rq_len[next_req], rq_id[next_req]);
                next_req++;
                ar_taken = 1'b1;
            end
        end

        if (cyc >= LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d bursts", done, rq_addr.size());
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule